// File: doc/BRIEF.md
# FFT Bin Peak Detector

This block sits behind the magnitude stage of a channelised receiver. It takes one FFT frame at a time as a stream of squared bin magnitudes. Each beat carries a bin index and a magnitude, and the final bin of the frame is flagged. The block picks out the strongest signal bins of that frame. With the default 256-bin frame and a 1280 MHz sample rate, each bin covers 5 MHz.

A bin becomes a candidate when its magnitude is strictly above a programmable threshold and is at least as large as both of its neighbours. A missing neighbour at either end of the frame counts as zero. A windowed FFT spreads one tone over several neighbouring bins. To avoid reporting that spread as several signals, any two reported bins must lie more than an exclusion radius apart. The radius is 2 or 3 bins, chosen by an input.

The block keeps a sorted list of at most four candidates. Once the frame has ended, it emits a header beat carrying the count, followed by the entries, strongest first.

Top module: `pkdet_top`

## Requirements
- R1: After reset, res_valid is low and stays low until a frame has been completed.
- R2: A bin is a candidate only if its magnitude is strictly greater than thr and is greater than or equal to both neighbours. At bin 0 and at the last bin of the frame, the missing neighbour is taken as 0. A bin whose magnitude equals thr is never reported.
- R3: At most four entries are reported per frame. They are the strongest surviving candidates, in descending magnitude order. Among equal magnitudes, the lower bin index is kept and ranked first.
- R4: The exclusion radius is 2 when rad_sel is 0 and 3 when rad_sel is 1. A candidate within the radius of a stored entry replaces that entry only if the candidate is strictly stronger. Otherwise the candidate is dropped. No two reported bins are within the radius of each other.
- R5: The header beat (res_valid=1, res_head=1, res_count=N) is visible two rising edges after the edge that accepts the bin with in_last=1. It is followed on consecutive cycles by exactly N entry beats (res_head=0) carrying res_bin and res_mag.
- R6: Every frame produces a header, including a frame with no detections (res_count=0 and no entry beats). Candidates never carry over from one frame to the next.
- R7: Idle cycles (in_valid=0) inside a frame do not change the result. A new frame may start on the cycle right after the last bin of the previous frame. thr and rad_sel must be held from the first bin of a frame until one cycle after its last bin. A frame must be at least 6 bins long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr | input | MAGW | Detection threshold |
| rad_sel | input | 1 | Exclusion radius select: 0 gives 2 bins, 1 gives 3 bins |
| in_valid | input | 1 | Bin beat valid |
| in_bin | input | BINW | Bin index, ascending within a frame |
| in_mag | input | MAGW | Squared magnitude of the bin |
| in_last | input | 1 | Marks the final bin of the frame |
| res_valid | output | 1 | Report beat valid |
| res_head | output | 1 | Marks the header beat |
| res_count | output | CNTW | Number of entries in this report |
| res_bin | output | BINW | Bin index of the entry |
| res_mag | output | MAGW | Magnitude of the entry |

## Verification
The bench aims at the frame edges, where a design that skips the zero neighbour would lose a peak in bin 0 or in the last bin. It also sets a magnitude exactly equal to the threshold, which a design using >= would report. Ties are tested with a plateau of two equal bins and with five equal, well-separated peaks: a design without the lower-index rule would report the later bin or keep the wrong four. A stronger bin arriving just after a weaker one inside the radius, and a pair of bins three apart swept over both radius settings, expose a design that keeps both or drops the wrong one. Back-to-back frames and empty frames catch a list that leaks between frames or a missing zero-count header.

// File: rtl/pkdet_pkg.sv
package pkdet_pkg;

  typedef enum logic [1:0] {RPT_IDLE, RPT_HEAD, RPT_BODY} rpt_state_e;

  // radius select: 0 -> 2 bins, 1 -> 3 bins
  function automatic int unsigned excl_radius(input logic sel);
    return sel ? 32'd3 : 32'd2;
  endfunction

  // candidate test: strictly above threshold, not below either neighbour
  function automatic logic is_peak(input int unsigned m, input int unsigned l,
                                   input int unsigned r, input int unsigned t);
    return (m > t) && (m >= l) && (m >= r);
  endfunction

  // newer bin lies within rad bins after older bin
  function automatic logic within_radius(input int unsigned newer, input int unsigned older,
                                         input int unsigned rad);
    return (newer >= older) && ((newer - older) <= rad);
  endfunction

endpackage

// File: rtl/pkdet_window.sv
module pkdet_window
  import pkdet_pkg::*;
#(
  parameter int MAGW = 16,
  parameter int BINW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MAGW-1:0] thr,
  input  logic            in_valid,
  input  logic [BINW-1:0] in_bin,
  input  logic [MAGW-1:0] in_mag,
  input  logic            in_last,
  output logic            cand_vld,
  output logic [BINW-1:0] cand_bin,
  output logic [MAGW-1:0] cand_mag,
  output logic            frame_end
);

  logic            have_cur;
  logic            tail;
  logic [MAGW-1:0] cur_mag;
  logic [MAGW-1:0] left_mag;
  logic [MAGW-1:0] right_mag;
  logic [BINW-1:0] cur_bin;
  logic            eval_en;

  // tail cycle: held bin is the last one, its right neighbour is zero
  assign right_mag = tail ? '0 : in_mag;
  assign eval_en   = tail | (in_valid & have_cur);
  assign cand_vld  = eval_en & is_peak(32'(cur_mag), 32'(left_mag), 32'(right_mag), 32'(thr));
  assign cand_bin  = cur_bin;
  assign cand_mag  = cur_mag;
  assign frame_end = tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_cur <= 1'b0;
      tail     <= 1'b0;
      cur_mag  <= '0;
      left_mag <= '0;
      cur_bin  <= '0;
    end else if (tail) begin
      if (in_valid) begin
        cur_mag  <= in_mag;
        cur_bin  <= in_bin;
        left_mag <= '0;
        have_cur <= 1'b1;
        tail     <= in_last;
      end else begin
        have_cur <= 1'b0;
        tail     <= 1'b0;
      end
    end else if (in_valid) begin
      left_mag <= have_cur ? cur_mag : '0;
      cur_mag  <= in_mag;
      cur_bin  <= in_bin;
      have_cur <= 1'b1;
      tail     <= in_last;
    end
  end

  // R5
  tail_has_bin_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> (tail && have_cur));

endmodule

// File: rtl/pkdet_list.sv
module pkdet_list
  import pkdet_pkg::*;
#(
  parameter int NPEAK = 4,
  parameter int MAGW  = 16,
  parameter int BINW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rad_sel,
  input  logic            cand_vld,
  input  logic [BINW-1:0] cand_bin,
  input  logic [MAGW-1:0] cand_mag,
  input  logic            frame_end,
  output logic            nxt_v   [NPEAK],
  output logic [BINW-1:0] nxt_bin [NPEAK],
  output logic [MAGW-1:0] nxt_mag [NPEAK]
);

  logic            lst_v   [NPEAK];
  logic [BINW-1:0] lst_bin [NPEAK];
  logic [MAGW-1:0] lst_mag [NPEAK];
  logic            w_v     [NPEAK];
  logic [BINW-1:0] w_bin   [NPEAK];
  logic [MAGW-1:0] w_mag   [NPEAK];
  int unsigned     rad;
  logic            hit;
  logic            keep;
  int              hj;
  int              pos;

  assign rad = excl_radius(rad_sel);

  always_comb begin
    hit = 1'b0;
    hj  = 0;
    for (int j = 0; j < NPEAK; j++) begin
      if (lst_v[j] && within_radius(32'(cand_bin), 32'(lst_bin[j]), rad)) begin
        hit = 1'b1;
        hj  = j;
      end
    end
    keep  = cand_vld && (!hit || (lst_mag[hj] < cand_mag));
    w_v   = lst_v;
    w_bin = lst_bin;
    w_mag = lst_mag;
    // remove the weaker neighbour being replaced
    if (keep && hit) begin
      for (int j = 0; j < NPEAK-1; j++) begin
        if (j >= hj) begin
          w_v[j]   = w_v[j+1];
          w_bin[j] = w_bin[j+1];
          w_mag[j] = w_mag[j+1];
        end
      end
      w_v[NPEAK-1] = 1'b0;
    end
    // rank: stored entries of equal magnitude come first (lower bins)
    pos = 0;
    for (int j = 0; j < NPEAK; j++) begin
      if (w_v[j] && (w_mag[j] >= cand_mag)) pos = pos + 1;
    end
    if (keep) begin
      for (int j = NPEAK-1; j > 0; j--) begin
        if (j > pos) begin
          w_v[j]   = w_v[j-1];
          w_bin[j] = w_bin[j-1];
          w_mag[j] = w_mag[j-1];
        end
      end
      for (int j = 0; j < NPEAK; j++) begin
        if (j == pos) begin
          w_v[j]   = 1'b1;
          w_bin[j] = cand_bin;
          w_mag[j] = cand_mag;
        end
      end
    end
  end

  assign nxt_v   = w_v;
  assign nxt_bin = w_bin;
  assign nxt_mag = w_mag;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      for (int j = 0; j < NPEAK; j++) begin
        lst_v[j]   <= 1'b0;
        lst_bin[j] <= '0;
        lst_mag[j] <= '0;
      end
    end else begin
      lst_v   <= w_v;
      lst_bin <= w_bin;
      lst_mag <= w_mag;
    end
  end

  for (genvar i = 0; i < NPEAK-1; i++) begin : g_order
    // R3
    order_chk: assert property (@(posedge clk) disable iff (rst)
      lst_v[i+1] |-> (lst_v[i] && (lst_mag[i] >= lst_mag[i+1])));
  end

  for (genvar i = 0; i < NPEAK; i++) begin : g_sp_i
    for (genvar j = i + 1; j < NPEAK; j++) begin : g_sp_j
      // R4
      spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (lst_v[i] && lst_v[j]) |->
          (!within_radius(32'(lst_bin[i]), 32'(lst_bin[j]), rad) &&
           !within_radius(32'(lst_bin[j]), 32'(lst_bin[i]), rad)));
    end
  end

endmodule

// File: rtl/pkdet_report.sv
module pkdet_report
  import pkdet_pkg::*;
#(
  parameter int NPEAK = 4,
  parameter int MAGW  = 16,
  parameter int BINW  = 8,
  parameter int CNTW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic            nxt_v   [NPEAK],
  input  logic [BINW-1:0] nxt_bin [NPEAK],
  input  logic [MAGW-1:0] nxt_mag [NPEAK],
  output logic            res_valid,
  output logic            res_head,
  output logic [CNTW-1:0] res_count,
  output logic [BINW-1:0] res_bin,
  output logic [MAGW-1:0] res_mag
);

  localparam int POSW = (NPEAK > 1) ? $clog2(NPEAK) : 1;

  rpt_state_e      state;
  logic [BINW-1:0] snap_bin [NPEAK];
  logic [MAGW-1:0] snap_mag [NPEAK];
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] n_nxt;
  logic [POSW-1:0] pos;
  logic            at_last;

  always_comb begin
    n_nxt = '0;
    for (int j = 0; j < NPEAK; j++) begin
      if (nxt_v[j]) n_nxt = n_nxt + CNTW'(1);
    end
  end

  assign at_last   = (CNTW'(pos) + CNTW'(1)) == cnt;
  assign res_valid = (state != RPT_IDLE);
  assign res_head  = (state == RPT_HEAD);
  assign res_count = cnt;
  assign res_bin   = snap_bin[pos];
  assign res_mag   = snap_mag[pos];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RPT_IDLE;
      cnt   <= '0;
      pos   <= '0;
      for (int j = 0; j < NPEAK; j++) begin
        snap_bin[j] <= '0;
        snap_mag[j] <= '0;
      end
    end else if (cap) begin
      snap_bin <= nxt_bin;
      snap_mag <= nxt_mag;
      cnt      <= n_nxt;
      pos      <= '0;
      state    <= RPT_HEAD;
    end else begin
      case (state)
        RPT_HEAD: begin
          pos   <= '0;
          state <= (cnt == '0) ? RPT_IDLE : RPT_BODY;
        end
        RPT_BODY: begin
          if (at_last) state <= RPT_IDLE;
          else         pos   <= pos + POSW'(1);
        end
        default: state <= RPT_IDLE;
      endcase
    end
  end

  // R5
  hdr_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (res_valid && res_head));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_count <= CNTW'(NPEAK)));

  // R3
  body_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_head && $past(res_valid && !res_head)) |-> (res_mag <= $past(res_mag)));

endmodule

// File: rtl/pkdet_top.sv
module pkdet_top #(
  parameter int NBINS = 256,
  parameter int MAGW  = 16,
  parameter int NPEAK = 4,
  localparam int BINW = $clog2(NBINS),
  localparam int CNTW = $clog2(NPEAK + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MAGW-1:0] thr,
  input  logic            rad_sel,
  input  logic            in_valid,
  input  logic [BINW-1:0] in_bin,
  input  logic [MAGW-1:0] in_mag,
  input  logic            in_last,
  output logic            res_valid,
  output logic            res_head,
  output logic [CNTW-1:0] res_count,
  output logic [BINW-1:0] res_bin,
  output logic [MAGW-1:0] res_mag
);

  logic            cand_vld;
  logic [BINW-1:0] cand_bin;
  logic [MAGW-1:0] cand_mag;
  logic            frame_end;
  logic            nxt_v   [NPEAK];
  logic [BINW-1:0] nxt_bin [NPEAK];
  logic [MAGW-1:0] nxt_mag [NPEAK];

  pkdet_window #(.MAGW(MAGW), .BINW(BINW)) u_win (
    .clk(clk), .rst(rst), .thr(thr),
    .in_valid(in_valid), .in_bin(in_bin), .in_mag(in_mag), .in_last(in_last),
    .cand_vld(cand_vld), .cand_bin(cand_bin), .cand_mag(cand_mag), .frame_end(frame_end)
  );

  pkdet_list #(.NPEAK(NPEAK), .MAGW(MAGW), .BINW(BINW)) u_list (
    .clk(clk), .rst(rst), .rad_sel(rad_sel),
    .cand_vld(cand_vld), .cand_bin(cand_bin), .cand_mag(cand_mag), .frame_end(frame_end),
    .nxt_v(nxt_v), .nxt_bin(nxt_bin), .nxt_mag(nxt_mag)
  );

  pkdet_report #(.NPEAK(NPEAK), .MAGW(MAGW), .BINW(BINW), .CNTW(CNTW)) u_rpt (
    .clk(clk), .rst(rst), .cap(frame_end),
    .nxt_v(nxt_v), .nxt_bin(nxt_bin), .nxt_mag(nxt_mag),
    .res_valid(res_valid), .res_head(res_head), .res_count(res_count),
    .res_bin(res_bin), .res_mag(res_mag)
  );

  // R1
  idle_in_reset_chk: assert property (@(posedge clk) rst |=> !res_valid);

endmodule

// File: tb/tb_pkdet_top.sv
module tb_pkdet_top;
  localparam int NBINS = 256;
  localparam int MAGW  = 16;
  localparam int NPEAK = 4;
  localparam int BINW  = 8;
  localparam int CNTW  = 3;
  localparam int MAXF  = 200;

  logic            clk = 1'b0;
  logic            rst;
  logic [MAGW-1:0] thr;
  logic            rad_sel;
  logic            in_valid;
  logic [BINW-1:0] in_bin;
  logic [MAGW-1:0] in_mag;
  logic            in_last;
  logic            res_valid, res_head;
  logic [CNTW-1:0] res_count;
  logic [BINW-1:0] res_bin;
  logic [MAGW-1:0] res_mag;

  always #5 clk = ~clk;

  pkdet_top #(.NBINS(NBINS), .MAGW(MAGW), .NPEAK(NPEAK)) dut (
    .clk(clk), .rst(rst), .thr(thr), .rad_sel(rad_sel),
    .in_valid(in_valid), .in_bin(in_bin), .in_mag(in_mag), .in_last(in_last),
    .res_valid(res_valid), .res_head(res_head), .res_count(res_count),
    .res_bin(res_bin), .res_mag(res_mag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int    exp_cnt [MAXF];
  int    exp_bin [MAXF][4];
  int    exp_mag [MAXF][4];
  int    exp_hdr [MAXF];
  string exp_tag [MAXF];
  int    nf_in = 0;
  int    got_cnt [MAXF];
  int    got_bin [MAXF][4];
  int    got_mag [MAXF][4];
  int    got_hdr [MAXF];
  int    got_n   [MAXF];
  int    nf_out = 0;
  int    cur_out = -1;
  int    fm [NBINS];

  // monitor: outputs depend on registered state only
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (res_head) begin
        if (nf_out < MAXF) begin
          got_cnt[nf_out] = int'(res_count);
          got_hdr[nf_out] = cyc;
          got_n[nf_out]   = 0;
          cur_out         = nf_out;
        end
        nf_out++;
      end else if (cur_out >= 0 && got_n[cur_out] < 4) begin
        got_bin[cur_out][got_n[cur_out]] = int'(res_bin);
        got_mag[cur_out][got_n[cur_out]] = int'(res_mag);
        got_n[cur_out]++;
      end
    end
  end

  // reference: greedy top-four list with neighbour exclusion
  task automatic model(int L, int t, int rad, int f);
    int n;
    int lb[4];
    int lm[4];
    n = 0;
    for (int k = 0; k < L; k++) begin
      int l, r, hj, p, top;
      bit take;
      l = (k > 0) ? fm[k-1] : 0;
      r = (k < L-1) ? fm[k+1] : 0;
      if (fm[k] > t && fm[k] >= l && fm[k] >= r) begin
        take = 1;
        hj = -1;
        for (int j = 0; j < n; j++) if (k - lb[j] <= rad) hj = j;
        if (hj >= 0) begin
          if (lm[hj] >= fm[k]) take = 0;
          else begin
            for (int j = hj; j < n-1; j++) begin lb[j] = lb[j+1]; lm[j] = lm[j+1]; end
            n--;
          end
        end
        if (take) begin
          p = n;
          for (int j = n-1; j >= 0; j--) if (lm[j] < fm[k]) p = j;
          if (p < 4) begin
            top = (n < 4) ? n : 3;
            for (int j = top; j > p; j--) begin lb[j] = lb[j-1]; lm[j] = lm[j-1]; end
            lb[p] = k;
            lm[p] = fm[k];
            if (n < 4) n++;
          end
        end
      end
    end
    exp_cnt[f] = n;
    for (int j = 0; j < n; j++) begin exp_bin[f][j] = lb[j]; exp_mag[f][j] = lm[j]; end
  endtask

  task automatic clear_fm();
    for (int k = 0; k < NBINS; k++) fm[k] = 0;
  endtask

  task automatic gen_random(int L);
    int npk;
    for (int k = 0; k < L; k++) fm[k] = int'($urandom % 40);
    npk = int'($urandom % 8);
    for (int i = 0; i < npk; i++) begin
      int p, m;
      p = int'($urandom % L);
      m = 100 + int'($urandom % 900);
      fm[p] = m;
      if (p > 0)   fm[p-1] = m / 2;
      if (p < L-1) fm[p+1] = m / 3;
    end
  endtask

  // called right after a falling edge
  task automatic send_frame(int L, int t, bit r, int gapp, bit idle_after, string tag);
    thr     = MAGW'(t);
    rad_sel = r;
    model(L, t, r ? 3 : 2, nf_in);
    exp_tag[nf_in] = tag;
    for (int k = 0; k < L; k++) begin
      if (gapp > 0 && ($urandom % gapp) == 0) begin
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_bin   = BINW'(k);
      in_mag   = MAGW'(fm[k]);
      in_last  = (k == L-1);
      if (k == L-1) exp_hdr[nf_in] = cyc + 2;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    nf_in++;
    if (idle_after) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; thr = '0; rad_sel = 1'b0;
    in_valid = 1'b0; in_bin = '0; in_mag = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
    end

    // R6: empty frame
    clear_fm();
    send_frame(16, 10, 0, 0, 1, "R6 empty");
    // R2: peaks at both frame edges
    clear_fm(); fm[0] = 500; fm[15] = 400;
    send_frame(16, 100, 0, 0, 1, "R2 edges");
    // R2: magnitude equal to threshold is not a detection
    clear_fm(); fm[5] = 100; fm[9] = 101;
    send_frame(16, 100, 0, 0, 1, "R2 equal-thr");
    // R2: a ramp has only its top as a peak
    clear_fm();
    for (int k = 0; k < 7; k++) fm[20+k] = 200 + 10*k;
    send_frame(32, 100, 0, 0, 1, "R2 ramp");
    // R3: six peaks, four strongest in order
    clear_fm(); fm[3] = 300; fm[10] = 700; fm[17] = 500; fm[24] = 900; fm[31] = 400; fm[38] = 800;
    send_frame(48, 100, 1, 0, 1, "R3 top4");
    // R3: equal magnitudes, lower bins kept first
    clear_fm(); fm[5] = 600; fm[15] = 600; fm[25] = 600; fm[35] = 600; fm[45] = 600;
    send_frame(56, 100, 0, 0, 1, "R3 ties");
    // R4: pair three apart under both radii
    clear_fm(); fm[10] = 500; fm[13] = 400;
    send_frame(24, 100, 0, 0, 1, "R4 rad2");
    send_frame(24, 100, 1, 0, 1, "R4 rad3");
    // R4: stronger later bin replaces, weaker later bin dropped
    clear_fm(); fm[10] = 400; fm[12] = 600; fm[14] = 500;
    send_frame(24, 100, 0, 0, 1, "R4 replace");
    // R4: plateau of equal bins
    clear_fm(); fm[30] = 700; fm[31] = 700;
    send_frame(40, 100, 1, 0, 1, "R4 plateau");
    // R7: back-to-back frames, then gapped frames
    gen_random(64);
    send_frame(64, 80, 0, 0, 0, "R7 b2b-a");
    gen_random(64);
    send_frame(64, 80, 0, 0, 1, "R7 b2b-b");
    gen_random(256);
    send_frame(256, 60, 1, 3, 1, "R7 full-gaps");
    for (int i = 0; i < 60; i++) begin
      gen_random(64);
      send_frame(64, 40 + int'($urandom % 80), 1'($urandom % 2), (i % 2) ? 4 : 0, 1, "R3 random");
    end
    repeat (20) @(negedge clk);

    chk(nf_out == nf_in, "R6", "header count", nf_out, nf_in);
    for (int f = 0; f < nf_in; f++) begin
      chk(got_cnt[f] == exp_cnt[f], exp_tag[f], "count", got_cnt[f], exp_cnt[f]);
      chk(got_hdr[f] == exp_hdr[f], "R5", "header cycle", got_hdr[f], exp_hdr[f]);
      chk(got_n[f] == exp_cnt[f], "R5", "entry beats", got_n[f], exp_cnt[f]);
      for (int e = 0; e < exp_cnt[f] && e < got_n[f]; e++) begin
        chk(got_bin[f][e] == exp_bin[f][e], exp_tag[f], "bin", got_bin[f][e], exp_bin[f][e]);
        chk(got_mag[f][e] == exp_mag[f][e], exp_tag[f], "mag", got_mag[f][e], exp_mag[f][e]);
      end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule